// File: doc/BRIEF.md
# Wide Serial Lane Interface Unit

This unit sits between the pins of a serial memory port and a byte-oriented memory command engine. It turns the bit stream into bytes and back. The stream arrives on one, two or four shared bidirectional lanes, and the width in use changes at run time by command. Each clock of `clk` is one serial bit clock, and a transfer lasts for as long as `cs_n` is low. The unit finds the opcode, the address bytes and the data bytes and hands each one on as a tagged byte. For reads, it takes the engine's next data byte and shifts it out over the lanes that are active.

Three commands change the lane width, and the width chosen survives deselection. The narrow interface accepts one command that widens the bus to two lanes and another that widens it to four. An all-ones opcode, sent at whatever width is in use, returns the bus to one lane. In the wide widths a read places a dummy byte time between the address and the first data byte, which leaves the host time to release the lanes. The pause function is allowed only when the fourth lane is not carrying data.

Top module: `wide_sio_unit`

## Requirements
- R1: After reset, `bus_width` is 2'b00 (single lane), `sio_oe` is 4'b0000, `rx_valid` is 0 and `hold_en` is 1.
- R2: Lane use per width. At width 2'b00, one bit per clock enters on sio_in[0] and leaves on sio_out[1]. At width 2'b01, two bits per clock use lanes [1:0]. At width 2'b10, four bits per clock use lanes [3:0]. A byte therefore takes 8, 4 or 2 clocks. Bits move most significant first, and within one clock the highest-numbered lane holds the most significant bit of the group. Inputs on lanes that the current width does not use are ignored.
- R3: `rx_valid` is high in exactly the last clock of each received byte, with the byte on `rx_byte`. `rx_tag` is 0 for the opcode, 1 for an address byte and 2 for a data byte. Opcodes 0x02 and 0x03 are followed by ADDR_BYTES (default 2) address bytes. After any other opcode that does not change the width, every later byte is tagged as data.
- R4: Opcode 0x3B received at width 2'b00 sets the width to 2'b01, and opcode 0x38 received at width 2'b00 sets it to 2'b10. The new width applies from the clock after the opcode's last clock. The opcode itself is still reported with tag 0, and no further bytes are reported in that selection.
- R5: Opcode 0xFF, sent at the current width (8, 4 or 2 clocks), sets the width to 2'b00 and blocks any further byte reports in that selection. At width 2'b00 it leaves the width unchanged.
- R6: Opcodes 0x3B and 0x38 received at width 2'b01 or 2'b10 do not change the width. They are reported as an ordinary opcode, and the bytes after them are reported as data.
- R7: The width stays the same across deselection. Only opcode 0xFF or an active-low `rst_n` changes it back to 2'b00, and the reset acts without waiting for a clock.
- R8: For read opcode 0x03 at width 2'b00, the data starts in the clock after the last address clock. At widths 2'b01 and 2'b10, a dummy byte of 4 or 2 clocks comes first, and every lane is released during it.
- R9: `sio_oe` is nonzero only during the read data phase. It is 4'b0010 at width 2'b00, 4'b0011 at width 2'b01 and 4'b1111 at width 2'b10. It drops to 4'b0000 in the same cycle that `cs_n` goes high.
- R10: `tx_take` is high in the last clock before each read data byte, which is the last address clock or the last dummy clock for the first byte and the last data clock for each later byte. `tx_byte` is captured at that clock edge, so reads run on for as long as the selection lasts.
- R11: `hold_en` is 0 at width 2'b10 and 1 at the other widths.
- R12: Raising `cs_n` part-way through a byte discards the partial byte, and the next selection starts again with an opcode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Asynchronous active-low reset, returns to single lane |
| cs_n | input | 1 | Active-low select framing one transfer |
| sio_in | input | 4 | Sampled lane levels |
| sio_out | output | 4 | Lane drive values |
| sio_oe | output | 4 | Per-lane output enables |
| bus_width | output | 2 | Current width: 00 one lane, 01 two lanes, 10 four lanes |
| hold_en | output | 1 | Pause function permitted |
| rx_valid | output | 1 | Received byte complete this clock |
| rx_byte | output | 8 | Received byte |
| rx_tag | output | 2 | 0 opcode, 1 address, 2 data |
| tx_byte | input | 8 | Next read byte from the command engine |
| tx_take | output | 1 | tx_byte captured at this clock edge |

## Verification
At each of the three widths, the bench sweeps all 256 data byte values through a write. It drives junk on the unused lanes at the same time, so a lane mapped wrongly or a bit order reversed shows up as a wrong byte. Reads at each width send an arithmetic byte sequence. Comparing each output group and each enable mask clock by clock separates a missing or misplaced dummy byte from an off-by-one capture of the engine's byte. Width commands are tried at the widths where they are valid and at the widths where they are not, and across deselection and reset. This separates a command that changes state from one that is only forwarded. Two further cases check that a partial byte is thrown away and that a deselect in the middle of a read releases the lanes at once.

// File: rtl/wide_sio_unit.sv
`timescale 1ns/1ps
module wide_sio_unit #(
  parameter int ADDR_BYTES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic [3:0] sio_in,
  output logic [3:0] sio_out,
  output logic [3:0] sio_oe,
  output logic [1:0] bus_width,
  output logic       hold_en,
  output logic       rx_valid,
  output logic [7:0] rx_byte,
  output logic [1:0] rx_tag,
  input  logic [7:0] tx_byte,
  output logic       tx_take
);
  localparam int AW = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
  localparam logic [AW-1:0] ALAST = AW'(ADDR_BYTES - 1);

  typedef enum logic [2:0] {PH_OP, PH_ADDR, PH_DUMMY, PH_RDATA, PH_WDATA, PH_SKIP} phase_t;

  logic [1:0]    width_q;
  phase_t        ph_q;
  logic [2:0]    cnt_q;
  logic [7:0]    sh_q, tx_q, sh_nx;
  logic [AW-1:0] ab_q;
  logic          rd_q;

  wire last      = cnt_q == (3'd7 >> width_q);
  wire addr_done = (ph_q == PH_ADDR) && (ab_q == ALAST);
  wire load      = !cs_n && last &&
                   ((addr_done && rd_q && width_q == 2'd0) || ph_q == PH_DUMMY || ph_q == PH_RDATA);

  always_comb begin
    case (width_q)
      2'd1:    sh_nx = {sh_q[5:0], sio_in[1:0]};
      2'd2:    sh_nx = {sh_q[3:0], sio_in};
      default: sh_nx = {sh_q[6:0], sio_in[0]};
    endcase
  end

  assign rx_valid  = !cs_n && last && (ph_q == PH_OP || ph_q == PH_ADDR || ph_q == PH_WDATA);
  assign rx_byte   = sh_nx;
  assign rx_tag    = (ph_q == PH_OP) ? 2'd0 : (ph_q == PH_ADDR) ? 2'd1 : 2'd2;
  assign tx_take   = load;
  assign bus_width = width_q;
  assign hold_en   = width_q != 2'd2;

  always_comb begin
    case (width_q)
      2'd1:    sio_out = {2'b00, tx_q[7:6]};
      2'd2:    sio_out = tx_q[7:4];
      default: sio_out = {2'b00, tx_q[7], 1'b0};
    endcase
  end

  wire drive = !cs_n && ph_q == PH_RDATA;
  assign sio_oe = !drive ? 4'b0000 : (width_q == 2'd2) ? 4'b1111 :
                  (width_q == 2'd1) ? 4'b0011 : 4'b0010;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      width_q <= 2'd0;
      ph_q    <= PH_OP;
      cnt_q   <= 3'd0;
      sh_q    <= 8'd0;
      tx_q    <= 8'd0;
      ab_q    <= '0;
      rd_q    <= 1'b0;
    end else if (cs_n) begin
      ph_q  <= PH_OP;
      cnt_q <= 3'd0;
      ab_q  <= '0;
      rd_q  <= 1'b0;
    end else begin
      sh_q  <= sh_nx;
      cnt_q <= last ? 3'd0 : cnt_q + 3'd1;
      if (ph_q == PH_RDATA) begin
        case (width_q)
          2'd1:    tx_q <= {tx_q[5:0], 2'b00};
          2'd2:    tx_q <= {tx_q[3:0], 4'b0000};
          default: tx_q <= {tx_q[6:0], 1'b0};
        endcase
      end
      if (load) tx_q <= tx_byte;
      if (last) begin
        case (ph_q)
          PH_OP: begin
            if (sh_nx == 8'hFF) begin
              width_q <= 2'd0;
              ph_q    <= PH_SKIP;
            end else if (width_q == 2'd0 && sh_nx == 8'h3B) begin
              width_q <= 2'd1;
              ph_q    <= PH_SKIP;
            end else if (width_q == 2'd0 && sh_nx == 8'h38) begin
              width_q <= 2'd2;
              ph_q    <= PH_SKIP;
            end else if (sh_nx == 8'h03 || sh_nx == 8'h02) begin
              ph_q <= PH_ADDR;
              rd_q <= sh_nx == 8'h03;
            end else begin
              ph_q <= PH_WDATA;
            end
          end
          PH_ADDR: begin
            if (ab_q == ALAST) ph_q <= !rd_q ? PH_WDATA : (width_q == 2'd0) ? PH_RDATA : PH_DUMMY;
            else ab_q <= ab_q + 1'b1;
          end
          PH_DUMMY: ph_q <= PH_RDATA;
          default: ;
        endcase
      end
    end
  end
endmodule

module wide_sio_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic [3:0] sio_oe,
  input logic [1:0] bus_width,
  input logic       rx_valid,
  input logic       tx_take
);
  AST_OE_RELEASED_DESEL: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> sio_oe == 4'b0000); // R9
  AST_OE_LEGAL_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    sio_oe == 4'b0000 || sio_oe == 4'b0010 || sio_oe == 4'b0011 || sio_oe == 4'b1111); // R9
  AST_WIDTH_LEGAL: assert property (@(posedge clk) disable iff (!rst_n) bus_width != 2'b11); // R2
  AST_WIDTH_HELD: assert property (@(posedge clk) disable iff (!rst_n) !rx_valid |=> $stable(bus_width)); // R7
  AST_NO_RX_DESEL: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !rx_valid); // R3
  AST_TAKE_THEN_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_take |=> (cs_n || sio_oe != 4'b0000)); // R10
  AST_NO_RX_WHILE_DRIVING: assert property (@(posedge clk) disable iff (!rst_n) sio_oe != 4'b0000 |-> !rx_valid); // R8
endmodule

bind wide_sio_unit wide_sio_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sio_oe(sio_oe),
  .bus_width(bus_width), .rx_valid(rx_valid), .tx_take(tx_take)
);

// File: tb/wide_sio_unit_bench.sv
`timescale 1ns/1ps
module wide_sio_unit_bench;
  logic       clk = 1'b0;
  logic       rst_n, cs_n;
  logic [3:0] sio_in, sio_out, sio_oe;
  logic [1:0] bus_width, rx_tag;
  logic       hold_en, rx_valid, tx_take;
  logic [7:0] rx_byte, tx_byte;
  int checks = 0;
  int errors = 0;
  logic last_take;

  always #5 clk = ~clk;

  wide_sio_unit u_wide_sio_unit (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sio_in(sio_in), .sio_out(sio_out),
    .sio_oe(sio_oe), .bus_width(bus_width), .hold_en(hold_en), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .rx_tag(rx_tag), .tx_byte(tx_byte), .tx_take(tx_take)
  );

  task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [3:0] grp(input logic [7:0] b, input int w, input int g);
    int bpc = 1 << w;
    return 4'((b >> (8 - bpc * (g + 1))) & ((1 << bpc) - 1));
  endfunction

  function automatic logic [3:0] in_mask(input int w);
    return (w == 0) ? 4'b0001 : (w == 1) ? 4'b0011 : 4'b1111;
  endfunction

  function automatic logic [3:0] oe_mask(input int w);
    return (w == 0) ? 4'b0010 : (w == 1) ? 4'b0011 : 4'b1111;
  endfunction

  function automatic logic [7:0] pat(input int i);
    return 8'(i * 37 + 5) ^ 8'h5A;
  endfunction

  task automatic send_byte(input logic [7:0] b, input int w, input bit exp_rx, input logic [1:0] tag, input string rq);
    int cpb = 8 >> w;
    for (int g = 0; g < cpb; g++) begin
      sio_in = grp(b, w, g) | (~in_mask(w) & 4'b1010);
      #1;
      if (g == cpb - 1) begin
        last_take = tx_take;
        if (exp_rx)
          check(rx_valid && rx_byte == b && rx_tag == tag, rq, {rx_valid, rx_tag, rx_byte}, {1'b1, tag, b});
        else
          check(!rx_valid, rq, 32'(rx_valid), 32'd0);
      end
      @(negedge clk);
    end
  endtask

  task automatic deselect();
    cs_n = 1'b1;
    sio_in = 4'h0;
    #1;
    check(sio_oe == 4'b0000, "R9", 32'(sio_oe), 32'd0);
    @(negedge clk);
  endtask

  task automatic wr_sweep(input int w);
    cs_n = 1'b0;
    send_byte(8'h02, w, 1'b1, 2'd0, "R3");
    send_byte(8'hA7, w, 1'b1, 2'd1, "R3");
    send_byte(8'h1C, w, 1'b1, 2'd1, "R3");
    for (int v = 0; v < 256; v++) send_byte(8'(v), w, 1'b1, 2'd2, "R2");
    deselect();
  endtask

  task automatic rd_seq(input int w, input logic [7:0] ahi, input logic [7:0] alo, input int n, input int base);
    int cpb = 8 >> w;
    tx_byte = pat(base);
    cs_n = 1'b0;
    send_byte(8'h03, w, 1'b1, 2'd0, "R3");
    send_byte(ahi, w, 1'b1, 2'd1, "R3");
    send_byte(alo, w, 1'b1, 2'd1, "R3");
    check(last_take == (w == 0), "R10", 32'(last_take), 32'(w == 0));
    if (w != 0) begin
      for (int d = 0; d < cpb; d++) begin
        sio_in = 4'h0;
        #1;
        check(sio_oe == 4'b0000, "R8", 32'(sio_oe), 32'd0);
        if (d == cpb - 1) check(tx_take, "R10", 32'(tx_take), 32'd1);
        @(negedge clk);
      end
    end
    tx_byte = pat(base + 1);
    for (int k = 0; k < n; k++) begin
      for (int g = 0; g < cpb; g++) begin
        logic [3:0] e;
        e = (w == 0) ? {2'b00, grp(pat(base + k), w, g)[0], 1'b0} : grp(pat(base + k), w, g);
        #1;
        check(sio_oe == oe_mask(w), "R9", 32'(sio_oe), 32'(oe_mask(w)));
        check((sio_out & oe_mask(w)) == e, "R2", 32'(sio_out & oe_mask(w)), 32'(e));
        if (g == cpb - 1) check(tx_take, "R10", 32'(tx_take), 32'd1);
        @(negedge clk);
        if (g == cpb - 1) tx_byte = pat(base + k + 2);
      end
    end
    deselect();
  endtask

  task automatic mode_cmd(input logic [7:0] op, input int w, input int nw, input string rq);
    cs_n = 1'b0;
    send_byte(op, w, 1'b1, 2'd0, rq);
    check(bus_width == 2'(nw), rq, 32'(bus_width), 32'(nw));
    send_byte(8'h02, nw, 1'b0, 2'd0, rq);
    deselect();
    check(bus_width == 2'(nw), "R7", 32'(bus_width), 32'(nw));
  endtask

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; sio_in = 4'h0; tx_byte = 8'h00; last_take = 1'b0;
    @(negedge clk); @(negedge clk);
    check(bus_width == 2'b00 && sio_oe == 4'b0000 && !rx_valid && hold_en, "R1",
          {bus_width, sio_oe, rx_valid, hold_en}, 32'b00_0000_0_1);
    rst_n = 1'b1;
    @(negedge clk);

    mode_cmd(8'hFF, 0, 0, "R5");
    wr_sweep(0);
    rd_seq(0, 8'h12, 8'h34, 4, 0);

    mode_cmd(8'h3B, 0, 1, "R4");
    check(hold_en, "R11", 32'(hold_en), 32'd1);
    wr_sweep(1);
    rd_seq(1, 8'h56, 8'h78, 4, 10);

    cs_n = 1'b0;
    send_byte(8'h38, 1, 1'b1, 2'd0, "R6");
    send_byte(8'h77, 1, 1'b1, 2'd2, "R6");
    deselect();
    check(bus_width == 2'b01, "R6", 32'(bus_width), 32'd1);

    mode_cmd(8'hFF, 1, 0, "R5");
    mode_cmd(8'h38, 0, 2, "R4");
    check(!hold_en, "R11", 32'(hold_en), 32'd0);
    wr_sweep(2);
    rd_seq(2, 8'h9A, 8'hBC, 3, 20);

    tx_byte = 8'hC6;
    cs_n = 1'b0;
    send_byte(8'h03, 2, 1'b1, 2'd0, "R3");
    send_byte(8'h00, 2, 1'b1, 2'd1, "R3");
    send_byte(8'h01, 2, 1'b1, 2'd1, "R3");
    for (int d = 0; d < 2; d++) begin sio_in = 4'h0; @(negedge clk); end
    #1;
    check(sio_oe == 4'b1111 && sio_out == 4'hC, "R9", {sio_oe, sio_out}, 32'hFC);
    cs_n = 1'b1;
    #1;
    check(sio_oe == 4'b0000, "R9", 32'(sio_oe), 32'd0);
    @(negedge clk);

    cs_n = 1'b0;
    sio_in = 4'hF;
    @(negedge clk);
    cs_n = 1'b1;
    @(negedge clk);
    cs_n = 1'b0;
    send_byte(8'h02, 2, 1'b1, 2'd0, "R12");
    send_byte(8'h44, 2, 1'b1, 2'd1, "R12");
    deselect();

    mode_cmd(8'hFF, 2, 0, "R5");
    check(hold_en, "R11", 32'(hold_en), 32'd1);

    cs_n = 1'b0;
    send_byte(8'h05, 0, 1'b1, 2'd0, "R3");
    send_byte(8'hC3, 0, 1'b1, 2'd2, "R3");
    deselect();

    mode_cmd(8'h3B, 0, 1, "R4");
    rst_n = 1'b0;
    #1;
    check(bus_width == 2'b00, "R7", 32'(bus_width), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule